// File: doc/BRIEF.md
# Two-Stage Look-Up Table Logic Cell

This block models one configurable logic cell. Two first-stage look-up tables each turn a 4-input word into one bit, and a small second-stage table combines those two bits with one extra input. Depending on how the cell is configured, it computes two unrelated 4-input functions or one function of five inputs. Each of the two outputs either shows the combinational result directly or the content of its own D flip-flop. Each flip-flop can also capture a plain external input in place of the table result.

The truth tables and mode bits sit in a configuration word. That word is shifted in one bit per clock while `cfg_en` is high, which puts the cell in configuration mode. When `cfg_en` falls after a complete word, the cell enters user mode and its outputs come alive. The configuration port has no back-pressure: the cell takes a bit on every clock edge at which `cfg_en` is high. Every other pin is a plain level.

Top module: `lut_cell`

## Requirements
- R1: With `sel5`=0 and both outputs combinational, `out_x` equals bit `in_a` of table F and `out_y` equals bit `in_b` of table G, with no clock edge in between.
- R2: With `sel5`=1, `out_x` follows table H, indexed by {`in_c`, G result, F result} (`in_c` is the MSB). With H = 8'hCA this gives `in_c` ? G : F, so the cell computes one 5-input function.
- R3: With `reg_x`/`reg_y` set, each output shows its flip-flop. The flip-flop loads at a rising edge where `ce`=1, so a new result appears one clock after the inputs that produced it.
- R4: With `ce`=0, a registered output holds its value whatever the inputs do.
- R5: With `dir_x` (or `dir_y`) set, that flip-flop loads `byp_x` (or `byp_y`) and ignores the look-up tables.
- R6: The configuration word is 45 bits, shifted MSB first. Its fields, from MSB down, are: F[15:0] at bits 44..29, G[15:0] at 28..13, H[7:0] at 12..5, `sel5` at bit 4, `dir_x` at 3, `dir_y` at 2, `reg_x` at 1 and `reg_y` at 0. Table bit i is selected by input value i.
- R7: Both outputs are 0 while `cfg_en` is high. They stay 0 after a session with fewer than 45 bits. User mode starts on the clock edge after `cfg_en` falls following a complete word.
- R8: An asynchronous low on `rst_n` forces both outputs and both flip-flops to 0. The cell then stays unconfigured until a new complete load.
- R9: When more than 45 bits are shifted in one session, only the last 45 are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Configuration mode; shifts `cfg_data` on each rising edge |
| cfg_data | input | 1 | Serial configuration bit, MSB first |
| in_a | input | 4 | Inputs of table F |
| in_b | input | 4 | Inputs of table G |
| in_c | input | 1 | Extra input of table H |
| byp_x | input | 1 | Direct data for flip-flop X |
| byp_y | input | 1 | Direct data for flip-flop Y |
| ce | input | 1 | Flip-flop clock enable |
| out_x | output | 1 | Output X |
| out_y | output | 1 | Output Y |

## Verification
The assertions assume three things. The mode bits change only while `cfg_en` is high. Every input is a defined 0 or 1 at each rising edge. `ce` and the direct inputs settle before the edge that samples them. The bench meets these by changing every input half a period after a rising edge. It also keeps `cfg_en` low in any cycle where registered behaviour is checked, so the hold and direct-path properties only ever see a stable configuration.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;
  localparam int H_K       = 3;  // second-stage table inputs
  localparam int CTRL_BITS = 5;  // sel5, dir_x, dir_y, reg_x, reg_y
  localparam int B_SEL5    = 4;
  localparam int B_DIR_X   = 3;
  localparam int B_DIR_Y   = 2;
  localparam int B_REG_X   = 1;
  localparam int B_REG_Y   = 0;
  typedef enum logic { SRC_LUT = 1'b0, SRC_DIRECT = 1'b1 } ff_src_e;
endpackage

// File: rtl/cfg_lut.sv
module cfg_lut #(
  parameter int K = 4
) (
  input  logic [(1<<K)-1:0] table_bits,
  input  logic [K-1:0]      idx,
  output logic              y
);
  assign y = table_bits[idx];
endmodule

// File: rtl/cell_cfg_shift.sv
module cell_cfg_shift #(
  parameter int W = 45
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_en,
  input  logic         cfg_data,
  output logic [W-1:0] cfg_word,
  output logic         done
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] FULL = CW'(W);

  logic [CW-1:0] cnt;
  logic          en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_word <= '0;
      cnt      <= '0;
      done     <= 1'b0;
      en_q     <= 1'b0;
    end else begin
      en_q <= cfg_en;
      if (cfg_en) begin
        cfg_word <= {cfg_word[W-2:0], cfg_data};
        done     <= 1'b0;
        if (!en_q)            cnt <= CW'(1);
        else if (cnt != FULL) cnt <= cnt + CW'(1);
      end else if (en_q && cnt == FULL) begin
        done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cell_ff.sv
module cell_ff (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic ce,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (clr) q <= 1'b0;
    else if (ce)  q <= d;
  end
endmodule

// File: rtl/lut_cell.sv
module lut_cell
  import lut_cell_pkg::*;
#(
  parameter int LUT_K = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_data,
  input  logic [LUT_K-1:0] in_a,
  input  logic [LUT_K-1:0] in_b,
  input  logic             in_c,
  input  logic             byp_x,
  input  logic             byp_y,
  input  logic             ce,
  output logic             out_x,
  output logic             out_y
);
  localparam int TT    = 1 << LUT_K;
  localparam int HT    = 1 << H_K;
  localparam int CFG_W = 2 * TT + HT + CTRL_BITS;

  logic [CFG_W-1:0] cfg;
  logic             cfg_done;

  cell_cfg_shift #(.W(CFG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_data(cfg_data),
    .cfg_word(cfg), .done(cfg_done)
  );

  // first stage: F (index 0) and G (index 1)
  logic [LUT_K-1:0] s1_in  [2];
  logic [TT-1:0]    s1_tab [2];
  logic [1:0]       s1;
  assign s1_in[0] = in_a;
  assign s1_in[1] = in_b;

  for (genvar i = 0; i < 2; i++) begin : g_stage1
    assign s1_tab[i] = cfg[CFG_W-1-i*TT -: TT];
    cfg_lut #(.K(LUT_K)) u_lut (
      .table_bits(s1_tab[i]), .idx(s1_in[i]), .y(s1[i])
    );
  end

  // second stage
  logic h_out;
  cfg_lut #(.K(H_K)) u_lut_h (
    .table_bits(cfg[CTRL_BITS +: HT]), .idx({in_c, s1[1], s1[0]}), .y(h_out)
  );

  logic live;
  assign live = cfg_done & ~cfg_en;

  logic [1:0] comb_v, q_v, ff_d, use_reg;
  ff_src_e    src [2];
  logic [1:0] byp;

  assign comb_v[0]  = cfg[B_SEL5] ? h_out : s1[0];
  assign comb_v[1]  = s1[1];
  assign src[0]     = ff_src_e'(cfg[B_DIR_X]);
  assign src[1]     = ff_src_e'(cfg[B_DIR_Y]);
  assign use_reg[0] = cfg[B_REG_X];
  assign use_reg[1] = cfg[B_REG_Y];
  assign byp        = {byp_y, byp_x};

  for (genvar i = 0; i < 2; i++) begin : g_out
    assign ff_d[i] = (src[i] == SRC_DIRECT) ? byp[i] : comb_v[i];
    cell_ff u_ff (
      .clk(clk), .rst_n(rst_n), .clr(~live), .ce(ce), .d(ff_d[i]), .q(q_v[i])
    );
  end

  assign out_x = live & (use_reg[0] ? q_v[0] : comb_v[0]);
  assign out_y = live & (use_reg[1] ? q_v[1] : comb_v[1]);
endmodule

// File: rtl/lut_cell_chk.sv
module lut_cell_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_en,
  input logic ce,
  input logic byp_x,
  input logic out_x,
  input logic out_y,
  input logic done,
  input logic reg_x,
  input logic dir_x
);
  // R7: nothing leaves the cell in configuration mode
  assert_quiet_in_cfg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |-> (!out_x && !out_y));

  // R7: nothing leaves the cell before a complete load
  assert_quiet_unloaded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (!out_x && !out_y));

  // R4: registered output holds while clock enable is low
  assert_hold_on_ce_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(done && !cfg_en && !ce) && done && !cfg_en && reg_x)
      |-> (out_x == $past(out_x)));

  // R5: direct path lands in the flip-flop one clock later
  assert_direct_path_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(done && !cfg_en && ce) && done && !cfg_en && reg_x && dir_x)
      |-> (out_x == $past(byp_x)));

  // R8: reset forces the outputs low
  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_low_R8: assert (!out_x && !out_y);
    end
  end
endmodule

bind lut_cell lut_cell_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .ce(ce), .byp_x(byp_x),
  .out_x(out_x), .out_y(out_y), .done(cfg_done),
  .reg_x(cfg[1]), .dir_x(cfg[3])
);

// File: tb/lut_cell_tb.sv
module lut_cell_tb;
  localparam int CFG_W = 45;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_en = 1'b0, cfg_data = 1'b0;
  logic [3:0] in_a = '0, in_b = '0;
  logic in_c = 1'b0, byp_x = 1'b0, byp_y = 1'b0, ce = 1'b0;
  logic out_x, out_y;
  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  lut_cell u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_data(cfg_data),
    .in_a(in_a), .in_b(in_b), .in_c(in_c), .byp_x(byp_x), .byp_y(byp_y),
    .ce(ce), .out_x(out_x), .out_y(out_y)
  );

  // stimulus table: {in_a, in_b, in_c}
  localparam logic [8:0] VEC [8] = '{
    9'b1111_0110_1, 9'b0111_1111_0, 9'b1111_1111_0, 9'b0000_0000_1,
    9'b1000_0001_0, 9'b1111_0000_1, 9'b0001_1011_0, 9'b0000_1110_1
  };

  localparam logic [15:0] T_AND = 16'h8000;
  localparam logic [15:0] T_XOR = 16'h6996;
  localparam logic [15:0] T_OR  = 16'hFFFE;
  localparam logic [7:0]  T_MUX = 8'hCA;

  function automatic logic [CFG_W-1:0] mkcfg(logic [15:0] f, logic [15:0] g,
      logic [7:0] h, logic sel5, logic dx, logic dy, logic rx, logic ry);
    return {f, g, h, sel5, dx, dy, rx, ry};
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic load(logic [CFG_W-1:0] w, int extra);
    cfg_en = 1'b1;
    for (int i = 0; i < extra; i++) begin
      cfg_data = 1'b1;
      @(negedge clk);
    end
    for (int i = CFG_W - 1; i >= 0; i--) begin
      cfg_data = w[i];
      @(negedge clk);
    end
    cfg_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    #1;
    check("R8 reset x", out_x, 1'b0);
    check("R8 reset y", out_y, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    in_a = 4'hF; in_b = 4'h1;
    #1;
    check("R7 unloaded x", out_x, 1'b0);
    check("R7 unloaded y", out_y, 1'b0);

    // R1 / R6: two independent 4-input functions
    @(negedge clk);
    load(mkcfg(T_AND, T_XOR, T_MUX, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0), 0);
    for (int v = 0; v < 8; v++) begin
      {in_a, in_b, in_c} = VEC[v];
      #1;
      check("R1/R6 F", out_x, T_AND[in_a]);
      check("R1/R6 G", out_y, T_XOR[in_b]);
      @(negedge clk);
    end

    // R2: one 5-input function
    load(mkcfg(T_OR, T_AND, T_MUX, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0), 0);
    for (int v = 0; v < 8; v++) begin
      {in_a, in_b, in_c} = VEC[v];
      in_b = in_a;
      #1;
      check("R2 5-input", out_x, in_c ? T_AND[in_a] : T_OR[in_a]);
      @(negedge clk);
    end

    // R7: config mode and aborted load keep outputs low
    load(mkcfg(T_AND, T_XOR, T_MUX, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0), 0);
    in_a = 4'hF; in_b = 4'h1;
    #1;
    check("R7 pre x", out_x, 1'b1);
    cfg_en = 1'b1; cfg_data = 1'b0;
    #1;
    check("R7 cfg mode x", out_x, 1'b0);
    check("R7 cfg mode y", out_y, 1'b0);
    for (int i = 0; i < 5; i++) @(negedge clk);
    cfg_en = 1'b0;
    @(negedge clk); @(negedge clk);
    #1;
    check("R7 short load x", out_x, 1'b0);
    check("R7 short load y", out_y, 1'b0);

    // R9: leading surplus bits are pushed out
    @(negedge clk);
    load(mkcfg(T_AND, T_XOR, T_MUX, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0), 3);
    in_a = 4'hF; in_b = 4'h3;
    #1;
    check("R9 surplus x", out_x, 1'b1);
    check("R9 surplus y", out_y, 1'b0);

    // R3 / R4 / R5: registered outputs, direct path on X
    @(negedge clk);
    load(mkcfg(T_AND, T_XOR, T_MUX, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1), 0);
    ce = 1'b1; byp_x = 1'b1; in_a = 4'h0; in_b = 4'h1;
    #1;
    check("R3 before edge x", out_x, 1'b0);
    check("R3 before edge y", out_y, 1'b0);
    @(negedge clk);
    check("R5 direct x", out_x, 1'b1);
    check("R3 registered y", out_y, 1'b1);
    ce = 1'b0; byp_x = 1'b0; in_b = 4'h3;
    @(negedge clk);
    check("R4 hold x", out_x, 1'b1);
    check("R4 hold y", out_y, 1'b1);
    ce = 1'b1; in_a = 4'hF;
    @(negedge clk);
    check("R5 lut ignored x", out_x, 1'b0);
    check("R3 update y", out_y, 1'b0);

    // R8: asynchronous reset in user mode drops the configuration
    in_b = 4'h1; byp_x = 1'b1;
    @(negedge clk);
    check("R8 pre reset y", out_y, 1'b1);
    #3 rst_n = 1'b0;
    #1;
    check("R8 async x", out_x, 1'b0);
    check("R8 async y", out_y, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R8 stays unloaded x", out_x, 1'b0);
    check("R8 stays unloaded y", out_y, 1'b0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule